// File: doc/BRIEF.md
# Dual Parity Bus Transceiver

This block joins, for each of two independent channels, an 8-bit A port to an 8-bit B port. A single parity line runs alongside the data and can carry a signal in either direction. Every bus is modelled as a separate input, output and output-enable, so the surrounding logic resolves the shared wires. Two active-low enables per channel select the mode:

- Send A to B, with odd parity generated on the parity line.
- Send B to A, with the parity line used as an input and checked against the B data.
- Send A to B with deliberately inverted parity, so that the error path can be exercised.
- Isolate both ports.

Each channel has its own clock and its own active-low clear. On every rising edge of its clock, the channel stores the result of the B-side parity check in an error register. The stored error is presented as an open-drain pull-low request. A parent chip uses the block to bridge two parity-protected data buses. It can then read or wire-OR the per-channel error lines.

Top module: `dual_parity_xcvr`

## Requirements
- R1: With enables oeAN=1 and oeBN=0 (active low), a channel drives bOut equal to aIn unchanged, with bOe=1 and aOe=0.
- R2: In the mode of R1, parOe=1 and parOut is chosen so that the 8 bOut bits plus parOut hold an odd number of ones (parOut=1 for 8'h00 and 8'hFF, 0 for 8'h7F).
- R3: With oeAN=0 and oeBN=1, a channel drives aOut equal to bIn unchanged, with aOe=1, bOe=0 and parOe=0, so the parity line acts as an input.
- R4: On each rising edge of a channel's clock, its error register loads the check result. Afterwards errPullLow=1 (pull the open-drain flag low) when bIn together with parIn hold an even number of ones, and errPullLow=0 (line released) when they hold an odd number.
- R5: Driving a channel's clrN low sets errPullLow=0 at once, without waiting for a clock edge. The clear wins over any clock edge that occurs while clrN is low.
- R6: With oeAN=0 and oeBN=0, a channel drives bOut=aIn with bOe=1 and parOe=1, and parOut carries inverted parity, so the nine bits hold an even number of ones. If these nine bits are fed back in B-to-A mode, errPullLow becomes 1.
- R7: With oeAN=1 and oeBN=1, aOe, bOe and parOe are all 0.
- R8: The channels are independent. Clearing, enabling or clocking one channel leaves the outputs and the error register of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCh | input | NUM_CH | Per-channel clock for the error register |
| clrN | input | NUM_CH | Per-channel asynchronous active-low clear of the error register |
| oeAN | input | NUM_CH | Per-channel active-low A-side enable |
| oeBN | input | NUM_CH | Per-channel active-low B-side enable |
| aIn | input | NUM_CH x DATA_W | A bus value seen at the pins |
| aOut | output | NUM_CH x DATA_W | Value driven onto the A bus |
| aOe | output | NUM_CH | A bus drive enable |
| bIn | input | NUM_CH x DATA_W | B bus value seen at the pins |
| bOut | output | NUM_CH x DATA_W | Value driven onto the B bus |
| bOe | output | NUM_CH | B bus drive enable |
| parIn | input | NUM_CH | Parity line value seen at the pin |
| parOut | output | NUM_CH | Value driven onto the parity line |
| parOe | output | NUM_CH | Parity line drive enable |
| errPullLow | output | NUM_CH | Open-drain error flag: 1 pulls the line low, 0 releases it |

## Verification
The bench builds the block with its defaults: NUM_CH=2 and DATA_W=8. With two channels in one build, the bench can hold an error on one channel while it clears or re-modes the other. With 8-bit data, the all-zero, all-one, seven-ones and four-ones patterns cover both parity outcomes. Every single-bit flip on data or parity can also be reached. The vector table runs on both channels. Directed tests then cover the clear racing a clock edge and the loop-back of inverted parity into the checker.

// File: rtl/pxcvr_pkg.sv
package pxcvr_pkg;

  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_A2B     = 2'b01,
    MODE_B2A     = 2'b10,
    MODE_FORCED  = 2'b11
  } xcvrMode_e;

  // strobes from the control decoder into the channel datapath
  typedef struct packed {
    logic drvA;    // drive A from B
    logic drvB;    // drive B from A
    logic drvPar;  // drive the parity line
    logic invPar;  // invert generated parity
  } xcvrStb_t;

endpackage

// File: rtl/pxcvr_ctrl.sv
module pxcvr_ctrl
  import pxcvr_pkg::*;
(
  input  logic     oeAN,
  input  logic     oeBN,
  output xcvrStb_t stb
);

  xcvrMode_e mode;

  always_comb begin
    unique case ({oeAN, oeBN})
      2'b10:   mode = MODE_A2B;
      2'b01:   mode = MODE_B2A;
      2'b00:   mode = MODE_FORCED;
      default: mode = MODE_ISOLATE;
    endcase
  end

  always_comb begin
    stb = '0;
    unique case (mode)
      MODE_A2B: begin
        stb.drvB   = 1'b1;
        stb.drvPar = 1'b1;
      end
      MODE_FORCED: begin
        stb.drvB   = 1'b1;
        stb.drvPar = 1'b1;
        stb.invPar = 1'b1;
      end
      MODE_B2A: stb.drvA = 1'b1;
      default:  stb = '0;
    endcase
  end

endmodule

// File: rtl/pxcvr_datapath.sv
module pxcvr_datapath
  import pxcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  xcvrStb_t          stb,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bOe,
  input  logic              parIn,
  output logic              parOut,
  output logic              parOe,
  output logic              errPullLow
);

  logic oddGen;
  logic checkOk;
  logic flagN;

  // odd parity: parity bit set when the data has an even count of ones
  assign oddGen  = ~(^aIn);
  assign checkOk = ^{bIn, parIn};

  assign bOut   = aIn;
  assign bOe    = stb.drvB;
  assign aOut   = bIn;
  assign aOe    = stb.drvA;
  assign parOut = oddGen ^ stb.invPar;
  assign parOe  = stb.drvPar;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) flagN <= 1'b1;
    else       flagN <= checkOk;
  end

  assign errPullLow = ~flagN;

endmodule

// File: rtl/dual_parity_xcvr.sv
module dual_parity_xcvr
  import pxcvr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic [NUM_CH-1:0]             clkCh,
  input  logic [NUM_CH-1:0]             clrN,
  input  logic [NUM_CH-1:0]             oeAN,
  input  logic [NUM_CH-1:0]             oeBN,
  input  logic [NUM_CH-1:0][DATA_W-1:0] aIn,
  output logic [NUM_CH-1:0][DATA_W-1:0] aOut,
  output logic [NUM_CH-1:0]             aOe,
  input  logic [NUM_CH-1:0][DATA_W-1:0] bIn,
  output logic [NUM_CH-1:0][DATA_W-1:0] bOut,
  output logic [NUM_CH-1:0]             bOe,
  input  logic [NUM_CH-1:0]             parIn,
  output logic [NUM_CH-1:0]             parOut,
  output logic [NUM_CH-1:0]             parOe,
  output logic [NUM_CH-1:0]             errPullLow
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    xcvrStb_t stb;

    pxcvr_ctrl ctrlI (
      .oeAN (oeAN[g]),
      .oeBN (oeBN[g]),
      .stb  (stb)
    );

    pxcvr_datapath #(.DATA_W(DATA_W)) dpI (
      .clk        (clkCh[g]),
      .clrN       (clrN[g]),
      .stb        (stb),
      .aIn        (aIn[g]),
      .aOut       (aOut[g]),
      .aOe        (aOe[g]),
      .bIn        (bIn[g]),
      .bOut       (bOut[g]),
      .bOe        (bOe[g]),
      .parIn      (parIn[g]),
      .parOut     (parOut[g]),
      .parOe      (parOe[g]),
      .errPullLow (errPullLow[g])
    );
  end

endmodule

// File: rtl/dual_parity_xcvr_chk.sv
module dual_parity_xcvr_chk #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input logic [NUM_CH-1:0]             clkCh,
  input logic [NUM_CH-1:0]             clrN,
  input logic [NUM_CH-1:0]             oeAN,
  input logic [NUM_CH-1:0]             oeBN,
  input logic [NUM_CH-1:0][DATA_W-1:0] aIn,
  input logic [NUM_CH-1:0][DATA_W-1:0] aOut,
  input logic [NUM_CH-1:0]             aOe,
  input logic [NUM_CH-1:0][DATA_W-1:0] bIn,
  input logic [NUM_CH-1:0][DATA_W-1:0] bOut,
  input logic [NUM_CH-1:0]             bOe,
  input logic [NUM_CH-1:0]             parIn,
  input logic [NUM_CH-1:0]             parOut,
  input logic [NUM_CH-1:0]             parOe,
  input logic [NUM_CH-1:0]             errPullLow
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R1 R2
    a2b_odd_parity_chk: assert property (@(posedge clkCh[g]) disable iff (!clrN[g])
      (oeAN[g] && !oeBN[g]) |-> (bOe[g] && !aOe[g] && parOe[g] && bOut[g] == aIn[g]
                                  && ^{bOut[g], parOut[g]}));
    // R3
    b2a_input_parity_chk: assert property (@(posedge clkCh[g]) disable iff (!clrN[g])
      (!oeAN[g] && oeBN[g]) |-> (aOe[g] && !bOe[g] && !parOe[g] && aOut[g] == bIn[g]));
    // R4
    flag_capture_chk: assert property (@(posedge clkCh[g]) disable iff (!clrN[g])
      1'b1 |=> (errPullLow[g] == ~^{$past(bIn[g]), $past(parIn[g])}));
    // R5
    clear_release_chk: assert property (@(posedge clkCh[g])
      !clrN[g] |-> !errPullLow[g]);
    // R6
    forced_even_chk: assert property (@(posedge clkCh[g]) disable iff (!clrN[g])
      (!oeAN[g] && !oeBN[g]) |-> (bOe[g] && parOe[g] && !(^{bOut[g], parOut[g]})));
    // R7
    isolate_chk: assert property (@(posedge clkCh[g]) disable iff (!clrN[g])
      (oeAN[g] && oeBN[g]) |-> !(aOe[g] || bOe[g] || parOe[g]));
  end

endmodule

bind dual_parity_xcvr dual_parity_xcvr_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chkI (.*);

// File: tb/dual_parity_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_parity_xcvr_tb_top;

  localparam int NUM_CH = 2;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [NUM_CH-1:0]             clrN = '1, oeAN = '1, oeBN = '1, parIn = '0;
  logic [NUM_CH-1:0][DATA_W-1:0] aIn = '0, bIn = '0;
  logic [NUM_CH-1:0][DATA_W-1:0] aOut, bOut;
  logic [NUM_CH-1:0]             aOe, bOe, parOut, parOe, errPullLow;

  dual_parity_xcvr #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
    .clkCh({NUM_CH{clk}}), .clrN(clrN), .oeAN(oeAN), .oeBN(oeBN),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .parIn(parIn), .parOut(parOut), .parOe(parOe), .errPullLow(errPullLow));

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // vector: oeAN oeBN | data | par | expParOe expParOut expAOe expBOe expErr
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {2'b10, 8'h00, 1'b0, 5'b11010},  // R1 R2
    {2'b10, 8'hFF, 1'b0, 5'b11010},  // R2
    {2'b10, 8'h7F, 1'b0, 5'b10010},  // R2
    {2'b00, 8'h00, 1'b0, 5'b10010},  // R6
    {2'b00, 8'h7F, 1'b0, 5'b11010},  // R6
    {2'b11, 8'hA5, 1'b0, 5'b00000},  // R7
    {2'b01, 8'h00, 1'b1, 5'b00100},  // R3 R4
    {2'b01, 8'h00, 1'b0, 5'b00101},  // R4 parity flip
    {2'b01, 8'hFF, 1'b1, 5'b00100},  // R4
    {2'b01, 8'hFF, 1'b0, 5'b00101},  // R4
    {2'b01, 8'hA5, 1'b1, 5'b00100},  // R4
    {2'b01, 8'hA4, 1'b1, 5'b00101},  // R4 data flip
    {2'b01, 8'h7F, 1'b0, 5'b00100},  // R4
    {2'b01, 8'h7F, 1'b1, 5'b00101}   // R4 parity flip
  };

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [DATA_W-1:0] lbData;
    logic              lbPar;
    #1 clrN = '0;
    #2;
    // R5 reset state
    check(errPullLow == '0, "R5 reset", int'(errPullLow), 0);
    @(negedge clk) clrN = '1;

    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int v = 0; v < NV; v++) begin
        @(negedge clk);
        {oeAN[ch], oeBN[ch]} = VEC[v][15:14];
        aIn[ch] = VEC[v][13:6];
        bIn[ch] = VEC[v][13:6];
        parIn[ch] = VEC[v][5];
        @(posedge clk);
        @(negedge clk);
        check(parOe[ch] == VEC[v][4], "R2 R3 R7 parOe", parOe[ch], VEC[v][4]);
        if (VEC[v][4]) check(parOut[ch] == VEC[v][3], "R2 R6 parOut", parOut[ch], VEC[v][3]);
        check(aOe[ch] == VEC[v][2], "R3 R7 aOe", aOe[ch], VEC[v][2]);
        check(bOe[ch] == VEC[v][1], "R1 R7 bOe", bOe[ch], VEC[v][1]);
        if (VEC[v][1]) check(bOut[ch] == VEC[v][13:6], "R1 bOut", bOut[ch], VEC[v][13:6]);
        if (VEC[v][2]) begin
          check(aOut[ch] == VEC[v][13:6], "R3 aOut", aOut[ch], VEC[v][13:6]);
          check(errPullLow[ch] == VEC[v][0], "R4 flag", errPullLow[ch], VEC[v][0]);
        end
      end
    end

    // R6 loop-back of forced parity on both channels
    for (int ch = 0; ch < NUM_CH; ch++) begin
      @(negedge clk);
      {oeAN[ch], oeBN[ch]} = 2'b00;
      aIn[ch] = 8'h3C;
      #1;
      lbData = bOut[ch];
      lbPar  = parOut[ch];
      check(lbPar == 1'b0, "R6 forced parOut 3C", lbPar, 0);
      @(negedge clk);
      {oeAN[ch], oeBN[ch]} = 2'b01;
      bIn[ch] = lbData;
      parIn[ch] = lbPar;
      @(posedge clk); @(negedge clk);
      check(errPullLow[ch] == 1'b1, "R6 loop-back error", errPullLow[ch], 1);
      // normal A2B loop-back gives no error
      {oeAN[ch], oeBN[ch]} = 2'b10;
      #1;
      lbData = bOut[ch];
      lbPar  = parOut[ch];
      @(negedge clk);
      {oeAN[ch], oeBN[ch]} = 2'b01;
      bIn[ch] = lbData;
      parIn[ch] = lbPar;
      @(posedge clk); @(negedge clk);
      check(errPullLow[ch] == 1'b0, "R2 loop-back clean", errPullLow[ch], 0);
    end

    // R5 R8: both hold an error, clear only channel 0 between edges
    @(negedge clk);
    oeAN = '0; oeBN = '1;
    bIn[0] = 8'h00; bIn[1] = 8'h00; parIn = '0;
    @(posedge clk); @(negedge clk);
    check(errPullLow == 2'b11, "R4 both flagged", int'(errPullLow), 3);
    #1 clrN[0] = 1'b0;
    #1;
    check(errPullLow[0] == 1'b0, "R5 async clear", errPullLow[0], 0);
    check(errPullLow[1] == 1'b1, "R8 other channel kept", errPullLow[1], 1);
    // R5 clear held across an edge with a bad check
    @(posedge clk); @(negedge clk);
    check(errPullLow[0] == 1'b0, "R5 clear beats edge", errPullLow[0], 0);
    // R8 re-mode channel 0 leaves channel 1 untouched
    oeAN[0] = 1'b1; oeBN[0] = 1'b0; aIn[0] = 8'h55;
    #1;
    check(aOe[1] == 1'b1 && bOe[1] == 1'b0, "R8 ch1 mode kept", {aOe[1], bOe[1]}, 2);
    check(aOut[1] == 8'h00, "R8 ch1 data kept", aOut[1], 0);
    @(negedge clk) clrN[0] = 1'b1;
    bIn[0] = 8'h01; parIn[0] = 1'b0;
    @(posedge clk); @(negedge clk);
    check(errPullLow[0] == 1'b0, "R4 ch0 good after clear", errPullLow[0], 0);
    check(errPullLow[1] == 1'b1, "R8 ch1 still flagged", errPullLow[1], 1);

    finish_up();
  end

endmodule